// File: doc/BRIEF.md
# Energy-Detect Link Pulse Controller

This block times link pulses for a two-port Ethernet PHY while its ports sit in energy-detect power-down. For each port it issues a periodic one-cycle request to send a normal link pulse, and it watches the received-pulse strobe to decide when the port should wake. All timing is counted in whole ticks of a 1 ms timebase, which the surrounding logic supplies as a one-cycle strobe.

Transmit requests can be gated per port, or held back until every port is powered down. Waking can follow a single received pulse, or it can require two pulses whose spacing stays within a selectable maximum gap. Configuration arrives as plain input fields that are held stable by the owning register block. Leaving power-down, or losing the transmit gating condition, discards any partial interval or pending first pulse.

Top module: `edlp_ctrl`

## Requirements
- R1: A port issues transmit requests only while `cfg_tx_en` is 1 and that port's `pd_state` bit is 1; with `cfg_tx_en` at 0 no transmit request is issued.
- R2: The transmit period in ms ticks is 1000 for `cfg_tx_sel`=00, 768 for 01, 512 for 10 and 256 for 11; the first request follows exactly one period of ticks after gating turns on, and later ones repeat every period.
- R3: With `cfg_single_wake` at 1, a received pulse on a powered-down port raises that port's `wake_req` in the next cycle.
- R4: With `cfg_single_wake` at 0, a second received pulse that arrives no more than the gap limit of ticks after the first raises `wake_req`; the limit is 64 ticks for `cfg_gap_sel`=00, 256 for 01, 512 for 10 and 1000 for 11.
- R5: A first received pulse alone never wakes a port in two-pulse mode; a second pulse arriving after more than the gap limit of ticks does not wake and is taken as a new first pulse.
- R6: With `cfg_indep` at 1, each port's transmit gating depends only on its own `pd_state` bit.
- R7: With `cfg_indep` at 0, transmit requests are issued only while both `pd_state` bits are 1.
- R8: During and right after reset both outputs are low; an all-zero configuration issues no transmit requests and uses two-pulse wake with the 64-tick gap.
- R9: When a port's transmit gating goes false, its interval count restarts, so the next request comes one full period after gating returns.
- R10: A wake is raised only for a pulse received while the port is powered down; leaving power-down discards a pending first pulse.
- R11: `tx_pulse` and `wake_req` are one-cycle strobes for each transmit event and each wake event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ms_tick_i | input | 1 | One-cycle strobe every 1 ms |
| cfg_tx_en | input | 1 | Enable transmit link-pulse requests |
| cfg_tx_sel | input | 2 | Transmit period select |
| cfg_single_wake | input | 1 | 1: wake on one received pulse; 0: two pulses needed |
| cfg_gap_sel | input | 2 | Maximum spacing select for two-pulse wake |
| cfg_indep | input | 1 | 1: per-port transmit gating; 0: all ports must be down |
| pd_state | input | 2 | Per-port energy-detect power-down state |
| rx_pulse | input | 2 | Per-port received link-pulse strobe |
| tx_pulse | output | 2 | Per-port transmit link-pulse request strobe |
| wake_req | output | 2 | Per-port wake request strobe |

## Verification
The hardest situations to reach are the edges of the two-pulse window: a second pulse exactly at the gap limit must wake while one a single tick later must not, and that late pulse must then act as a fresh first pulse. The bench drives the timebase itself, one tick every two cycles, and places the received strobes on cycles with no tick so the tick count between the two pulses is exact. The same exact counting pins down the first transmit request at one full period after gating and its restart after a short exit from power-down.

// File: rtl/edlp_pkg.sv
package edlp_pkg;

  localparam int unsigned NUM_PORTS_DEF = 2;
  localparam int unsigned CNT_W_DEF     = 10;

  // Transmit period in ms ticks for each select code
  function automatic int unsigned tx_interval_ms(input logic [1:0] sel);
    int unsigned v;
    case (sel)
      2'b00:   v = 1000;
      2'b01:   v = 768;
      2'b10:   v = 512;
      default: v = 256;
    endcase
    return v;
  endfunction

  // Largest allowed spacing between two received pulses, in ms ticks
  function automatic int unsigned gap_limit_ms(input logic [1:0] sel);
    int unsigned v;
    case (sel)
      2'b00:   v = 64;
      2'b01:   v = 256;
      2'b10:   v = 512;
      default: v = 1000;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/edlp_tx_gate.sv
module edlp_tx_gate #(
  parameter int unsigned NUM_PORTS = 2
) (
  input  logic                 tx_en_i,
  input  logic                 indep_i,
  input  logic [NUM_PORTS-1:0] pd_i,
  output logic [NUM_PORTS-1:0] gate_o
);

  logic all_down;
  assign all_down = &pd_i;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign gate_o[p] = tx_en_i & pd_i[p] & (indep_i | all_down);
  end

endmodule

// File: rtl/edlp_tx_timer.sv
module edlp_tx_timer #(
  parameter int unsigned CNT_W = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       gate_i,
  input  logic [1:0] sel_i,
  output logic       tx_pulse_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_c;
  logic             period_end;
  logic             fire;

  assign last_c     = CNT_W'(edlp_pkg::tx_interval_ms(sel_i) - 1);
  assign period_end = (cnt_q >= last_c);
  assign fire       = gate_i & tick_i & period_end;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      tx_pulse_o <= 1'b0;
    end else begin
      tx_pulse_o <= fire;
      if (!gate_i) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (period_end) cnt_q <= '0;
        else            cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  a_r1_tx_needs_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pulse_o |-> $past(gate_i && tick_i));

  a_r9_restart_when_ungated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_i |=> (cnt_q == '0));

  a_r2_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_i && tick_i && !period_end) |=> (cnt_q != '0));

endmodule

// File: rtl/edlp_wake_det.sv
module edlp_wake_det #(
  parameter int unsigned CNT_W = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       pd_i,
  input  logic       rx_i,
  input  logic       single_i,
  input  logic [1:0] gap_sel_i,
  output logic       wake_o
);

  logic             armed_q;
  logic [CNT_W-1:0] gap_q;
  logic [CNT_W-1:0] limit_c;
  logic             rx_ev;
  logic             in_window;
  logic             wake_hit;
  logic             expire;

  assign limit_c   = CNT_W'(edlp_pkg::gap_limit_ms(gap_sel_i));
  assign rx_ev     = pd_i & rx_i;
  assign in_window = armed_q & (gap_q <= limit_c);
  assign wake_hit  = rx_ev & (single_i | in_window);
  assign expire    = armed_q & tick_i & (gap_q >= limit_c);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      gap_q   <= '0;
      wake_o  <= 1'b0;
    end else begin
      wake_o <= wake_hit;
      if (!pd_i) begin
        armed_q <= 1'b0;
        gap_q   <= '0;
      end else if (rx_ev) begin
        armed_q <= ~wake_hit;
        gap_q   <= '0;
      end else if (expire) begin
        armed_q <= 1'b0;
        gap_q   <= '0;
      end else if (armed_q && tick_i) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  a_r3_single_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_i && pd_i && single_i) |=> wake_o);

  a_r10_wake_needs_pd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(pd_i && rx_i));

  a_r5_first_pulse_no_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ev && !single_i && !armed_q) |=> !wake_o);

  a_r10_pd_exit_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_i |=> !armed_q);

endmodule

// File: rtl/edlp_ctrl.sv
module edlp_ctrl #(
  parameter int unsigned NUM_PORTS = edlp_pkg::NUM_PORTS_DEF,
  parameter int unsigned CNT_W     = edlp_pkg::CNT_W_DEF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ms_tick_i,
  input  logic                 cfg_tx_en,
  input  logic [1:0]           cfg_tx_sel,
  input  logic                 cfg_single_wake,
  input  logic [1:0]           cfg_gap_sel,
  input  logic                 cfg_indep,
  input  logic [NUM_PORTS-1:0] pd_state,
  input  logic [NUM_PORTS-1:0] rx_pulse,
  output logic [NUM_PORTS-1:0] tx_pulse,
  output logic [NUM_PORTS-1:0] wake_req
);

  logic [NUM_PORTS-1:0] tx_gate;

  edlp_tx_gate #(.NUM_PORTS(NUM_PORTS)) u_gate (
    .tx_en_i (cfg_tx_en),
    .indep_i (cfg_indep),
    .pd_i    (pd_state),
    .gate_o  (tx_gate)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    edlp_tx_timer #(.CNT_W(CNT_W)) u_tx (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (ms_tick_i),
      .gate_i     (tx_gate[p]),
      .sel_i      (cfg_tx_sel),
      .tx_pulse_o (tx_pulse[p])
    );

    edlp_wake_det #(.CNT_W(CNT_W)) u_wake (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (ms_tick_i),
      .pd_i      (pd_state[p]),
      .rx_i      (rx_pulse[p]),
      .single_i  (cfg_single_wake),
      .gap_sel_i (cfg_gap_sel),
      .wake_o    (wake_req[p])
    );

    a_r7_shared_needs_all_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tx_pulse[p] && !$past(cfg_indep)) |-> $past(&pd_state));

    a_r6_own_port_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tx_pulse[p] |-> $past(pd_state[p] && cfg_tx_en));

    a_r11_tx_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tx_pulse[p] |=> !tx_pulse[p]);
  end

endmodule

// File: tb/edlp_ctrl_tb.sv
`timescale 1ns/1ps
module edlp_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0;
  logic       cfg_tx_en = 1'b0;
  logic [1:0] cfg_tx_sel = 2'b00;
  logic       cfg_single_wake = 1'b0;
  logic [1:0] cfg_gap_sel = 2'b00;
  logic       cfg_indep = 1'b0;
  logic [1:0] pd_state = 2'b00;
  logic [1:0] rx_pulse = 2'b00;
  logic [1:0] tx_pulse;
  logic [1:0] wake_req;

  int checks = 0;
  int errors = 0;
  int ms_now = 0;
  int tx_seen [2];
  int tx_last [2];
  int wake_seen [2];
  int doubles = 0;
  logic [1:0] tx_prev = 2'b00;
  logic [1:0] wake_prev = 2'b00;

  always #2.5 clk = ~clk;

  edlp_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ms_tick_i(ms_tick),
    .cfg_tx_en(cfg_tx_en), .cfg_tx_sel(cfg_tx_sel),
    .cfg_single_wake(cfg_single_wake), .cfg_gap_sel(cfg_gap_sel),
    .cfg_indep(cfg_indep), .pd_state(pd_state), .rx_pulse(rx_pulse),
    .tx_pulse(tx_pulse), .wake_req(wake_req)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One clock: drive inputs, take the edge, sample 1 ns later
  task automatic cyc(input logic t, input logic [1:0] rx);
    ms_tick  = t;
    rx_pulse = rx;
    @(posedge clk);
    #1;
    ms_tick  = 1'b0;
    rx_pulse = 2'b00;
    if (t) ms_now++;
    for (int i = 0; i < 2; i++) begin
      if (tx_pulse[i]) begin tx_seen[i]++; tx_last[i] = ms_now; end
      if (wake_req[i]) wake_seen[i]++;
      if ((tx_pulse[i] && tx_prev[i]) || (wake_req[i] && wake_prev[i])) doubles++;
    end
    tx_prev   = tx_pulse;
    wake_prev = wake_req;
  endtask

  task automatic run_ms(input int n);
    for (int k = 0; k < n; k++) begin cyc(1'b1, 2'b00); cyc(1'b0, 2'b00); end
  endtask

  task automatic clear_obs();
    ms_now = 0;
    for (int i = 0; i < 2; i++) begin tx_seen[i] = 0; tx_last[i] = 0; wake_seen[i] = 0; end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    pd_state = 2'b11;
    repeat (3) cyc(1'b1, 2'b11);
    check(tx_pulse == 2'b00 && wake_req == 2'b00, "R8 outputs low in reset", {tx_pulse, wake_req}, 0);
    rst_n = 1'b1;
    clear_obs();
    cyc(1'b0, 2'b00);
    check(tx_pulse == 2'b00 && wake_req == 2'b00, "R8 outputs low after reset", {tx_pulse, wake_req}, 0);
    run_ms(1100);
    check(tx_seen[0] + tx_seen[1] == 0, "R8/R1 zero config no tx", tx_seen[0] + tx_seen[1], 0);
    // zero config: two-pulse wake with 64 tick gap
    cyc(1'b0, 2'b01);
    check(wake_seen[0] == 0, "R8 first pulse no wake", wake_seen[0], 0);
    run_ms(64);
    cyc(1'b0, 2'b01);
    check(wake_seen[0] == 1, "R8 default gap 64 wake", wake_seen[0], 1);
  endtask

  task automatic t_interval(input logic [1:0] sel, input int iv);
    cfg_tx_en = 1'b1; cfg_indep = 1'b1; cfg_tx_sel = sel;
    pd_state = 2'b00;
    cyc(1'b0, 2'b00);
    clear_obs();
    pd_state = 2'b11;
    run_ms(iv - 1);
    check(tx_seen[0] == 0, "R2 no tx before period", tx_seen[0], 0);
    run_ms(1);
    check(tx_seen[0] == 1 && tx_last[0] == iv, "R2 first tx at period", tx_last[0], iv);
    run_ms(iv);
    check(tx_seen[1] == 2 && tx_last[1] == 2 * iv, "R2 second tx at two periods", tx_last[1], 2 * iv);
  endtask

  task automatic t_indep();
    cfg_tx_en = 1'b1; cfg_indep = 1'b1; cfg_tx_sel = 2'b11;
    pd_state = 2'b00; cyc(1'b0, 2'b00); clear_obs();
    pd_state = 2'b01;
    run_ms(300);
    check(tx_seen[0] == 1 && tx_last[0] == 256, "R6 port0 alone pulses", tx_last[0], 256);
    check(tx_seen[1] == 0, "R6 port1 up stays quiet", tx_seen[1], 0);
  endtask

  task automatic t_shared();
    cfg_tx_en = 1'b1; cfg_indep = 1'b0; cfg_tx_sel = 2'b11;
    pd_state = 2'b00; cyc(1'b0, 2'b00); clear_obs();
    pd_state = 2'b01;
    run_ms(300);
    check(tx_seen[0] + tx_seen[1] == 0, "R7 one port down no tx", tx_seen[0] + tx_seen[1], 0);
    clear_obs();
    pd_state = 2'b11;
    run_ms(256);
    check(tx_seen[0] == 1 && tx_seen[1] == 1 && tx_last[0] == 256, "R7 both down tx", tx_last[0], 256);
  endtask

  task automatic t_restart();
    cfg_tx_en = 1'b1; cfg_indep = 1'b1; cfg_tx_sel = 2'b11;
    pd_state = 2'b00; cyc(1'b0, 2'b00);
    pd_state = 2'b11;
    run_ms(200);
    pd_state = 2'b00; cyc(1'b0, 2'b00);
    pd_state = 2'b11; clear_obs();
    run_ms(200);
    check(tx_seen[0] == 0, "R9 count restarted", tx_seen[0], 0);
    run_ms(56);
    check(tx_seen[0] == 1 && tx_last[0] == 256, "R9 tx one period after return", tx_last[0], 256);
    cfg_tx_en = 1'b0; clear_obs();
    run_ms(300);
    check(tx_seen[0] + tx_seen[1] == 0, "R1 enable off no tx", tx_seen[0] + tx_seen[1], 0);
  endtask

  task automatic t_single();
    cfg_tx_en = 1'b0; cfg_single_wake = 1'b1;
    pd_state = 2'b01; clear_obs();
    cyc(1'b0, 2'b01);
    check(wake_req[0] == 1'b1, "R3 single pulse wake", wake_req[0], 1);
    cyc(1'b0, 2'b00);
    check(wake_req[0] == 1'b0, "R11 wake one cycle", wake_req[0], 0);
    cyc(1'b0, 2'b10);
    check(wake_seen[1] == 0, "R10 port not down no wake", wake_seen[1], 0);
    cfg_single_wake = 1'b0;
  endtask

  task automatic t_gap(input logic [1:0] sel, input int lim);
    cfg_single_wake = 1'b0; cfg_gap_sel = sel;
    pd_state = 2'b00; cyc(1'b0, 2'b00);
    pd_state = 2'b01; clear_obs();
    cyc(1'b0, 2'b01);
    run_ms(lim);
    cyc(1'b0, 2'b01);
    check(wake_seen[0] == 1, "R4 second pulse at limit wakes", wake_seen[0], 1);
    cyc(1'b0, 2'b01);
    run_ms(lim + 1);
    cyc(1'b0, 2'b01);
    check(wake_seen[0] == 1, "R5 late second pulse no wake", wake_seen[0], 1);
    run_ms(10);
    cyc(1'b0, 2'b01);
    check(wake_seen[0] == 2, "R5 late pulse acts as new first", wake_seen[0], 2);
  endtask

  task automatic t_pd_exit();
    cfg_single_wake = 1'b0; cfg_gap_sel = 2'b01;
    pd_state = 2'b01; clear_obs();
    cyc(1'b0, 2'b01);
    run_ms(5);
    pd_state = 2'b00; cyc(1'b0, 2'b00);
    pd_state = 2'b01;
    cyc(1'b0, 2'b01);
    check(wake_seen[0] == 0, "R10 pd exit drops first pulse", wake_seen[0], 0);
    run_ms(3);
    cyc(1'b0, 2'b01);
    check(wake_seen[0] == 1, "R10 wake after rearm", wake_seen[0], 1);
  endtask

  initial begin
    t_reset();
    t_interval(2'b00, 1000);
    t_interval(2'b01, 768);
    t_interval(2'b10, 512);
    t_interval(2'b11, 256);
    t_indep();
    t_shared();
    t_restart();
    t_single();
    t_gap(2'b00, 64);
    t_gap(2'b10, 512);
    t_gap(2'b11, 1000);
    t_pd_exit();
    check(doubles == 0, "R11 strobes single cycle", doubles, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule